// File: doc/BRIEF.md
# External Memory Bus Controller

This controller joins a simple 32-bit internal request port to an external memory bus with four active-low chip selects. It has a small register space that holds one 8-bit configuration byte per chip select. Each byte sets the access length (wait states), the timing style (synchronous or asynchronous), whether writes are allowed, and the external data width. A key register guards the configuration bytes. A byte can only be changed after the key value has been written, and each successful change re-arms the guard.

A memory request is steered by address bits 25:24 to one chip select. The controller then issues the 32-bit word as one, two or four external beats, according to the width of that chip select. Beats go out in ascending address order. Read data is gathered little-endian, and each beat is held for the configured number of cycles. The request port uses a valid/ready handshake. A one-cycle `done` pulse returns the read data and an error flag.

Top module: `ext_mem_ctrl`

## Requirements
- R1: After reset, every configuration byte reads 0xF0 and the key register reads 1 (guarded). The controller is idle: `req_ready`=1, `done`=0, all chip selects high, both strobes high.
- R2: Bits 7:4 of a configuration byte are a wait code n. Each external beat keeps its strobe low for n+2 cycles, except that codes 0xE and 0xF both give 16 cycles.
- R3: Bit 3 set (synchronous) adds one capture cycle after the strobe cycles of every beat, with the chip select still low and both strobes high. Bit 3 clear samples read data on the last strobe cycle. The request latency in cycles after acceptance is beats × (strobe cycles + bit 3).
- R4: With bit 2 (write allow) clear, a write request gives `done` with `err`=1 in the cycle after acceptance. No strobe and no chip select is driven. Reads and permitted writes return `err`=0.
- R5: Bits 1:0 set the width: 00 gives four byte beats, 01 gives two halfword beats, 10 or 11 gives one 32-bit beat. Beat k uses external address (request address with bits 1:0 cleared) + k × beat bytes. It carries request bytes from position k × beat bytes upward on the low lanes of `mem_wdata`. Read byte i of the word comes from external byte address base+i.
- R6: Register accesses (`req_cfg`=1) use offset `req_addr[5:0]`. Configuration bytes sit at 0x00, 0x04, 0x08 and 0x0C for chip selects 0..3, and the key register sits at 0x20. A configuration write while guarded leaves the byte unchanged.
- R7: Writing 0xA05F (low 16 bits) to the key register unguards. Writing any other value guards. The first successful configuration write guards again. A read of the key register returns 1 when guarded and 0 when open.
- R8: During a memory access, exactly the chip select named by request address bits 25:24 is low, and never more than one. Output enable and write strobe are never low together.
- R9: `req_ready` is low from the acceptance edge until after the one-cycle `done` pulse. Register accesses show `done` in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request is accepted this cycle |
| req_cfg | input | 1 | 1 selects register space, 0 selects external memory |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 26 | Byte address; bits 25:24 pick the chip select; bits 5:0 are the register offset |
| req_wdata | input | 32 | Write data |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Write refused, valid with `done` |
| rdata | output | 32 | Read data, valid with `done` |
| mem_cs_n | output | 4 | Active-low chip selects |
| mem_addr | output | 26 | External byte address of the current beat |
| mem_oe_n | output | 1 | Active-low output enable (read strobe) |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_wdata | output | 32 | Beat write data on the low lanes |
| mem_rdata | input | 32 | External read data |

## Verification
The bench uses the default parameters: four chip selects, a 26-bit address and a 6-bit register offset. With only four selects and four width codes, it can sweep every chip select against every width code, six wait codes that include both saturating values, and both timing styles. That covers both the longest and the shortest beat trains. The external responder derives each byte from its own address, so lane order and beat addresses show directly in the assembled word.

// File: rtl/emc_pkg.sv
package emc_pkg;

  localparam int CFG_W = 8;
  localparam int WS_W  = 4;
  localparam int CNT_W = 5;
  localparam logic [15:0] UNLOCK_KEY = 16'hA05F;

  typedef struct packed {
    logic [WS_W-1:0] ws;
    logic            sync;
    logic            wren;
    logic [1:0]      width;
  } cs_cfg_t;

  localparam cs_cfg_t CFG_RESET = cs_cfg_t'(8'hF0);

  // strobe cycles per beat; the top two codes saturate at 16
  function automatic logic [CNT_W-1:0] beat_len(input logic [WS_W-1:0] ws);
    if (ws >= 4'hE) return CNT_W'(16);
    return {1'b0, ws} + CNT_W'(2);
  endfunction

  // number of external beats per 32-bit word
  function automatic logic [2:0] beat_count(input logic [1:0] w);
    case (w)
      2'b00:   return 3'd4;
      2'b01:   return 3'd2;
      default: return 3'd1;
    endcase
  endfunction

  // byte offset of beat k inside the word
  function automatic logic [1:0] beat_offset(input logic [1:0] beat, input logic [1:0] w);
    case (w)
      2'b00:   return beat;
      2'b01:   return {beat[0], 1'b0};
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic [31:0] lane_data(input logic [31:0] d, input logic [1:0] beat,
                                            input logic [1:0] w);
    return d >> {beat_offset(beat, w), 3'b000};
  endfunction

  function automatic logic [31:0] merge_lane(input logic [31:0] acc, input logic [31:0] rd,
                                             input logic [1:0] beat, input logic [1:0] w);
    logic [31:0] r;
    r = acc;
    case (w)
      2'b00:   r[{beat, 3'b000} +: 8]     = rd[7:0];
      2'b01:   r[{beat[0], 4'b0000} +: 16] = rd[15:0];
      default: r = rd;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/emc_cfg_regs.sv
module emc_cfg_regs
  import emc_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int OFS_W  = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [OFS_W-1:0]        ofs,
  input  logic [15:0]             wr_data,
  output cs_cfg_t [NUM_CS-1:0]    cfg_q,
  output logic [31:0]             rd_data
);

  localparam int IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;
  localparam logic [OFS_W-1:0] CFG_LIMIT = OFS_W'(NUM_CS * 4);
  localparam logic [OFS_W-1:0] KEY_OFS   = OFS_W'(32);

  cs_cfg_t [NUM_CS-1:0] regs_q;
  logic                 locked_q;
  logic                 cfg_hit, key_hit_addr, key_hit, cfg_wr_ok;
  logic [IDX_W-1:0]     cfg_idx;

  assign cfg_hit      = (ofs < CFG_LIMIT) && (ofs[1:0] == 2'b00);
  assign key_hit_addr = (ofs == KEY_OFS);
  assign cfg_idx      = ofs[IDX_W+1:2];
  assign key_hit      = wr_en && key_hit_addr;
  assign cfg_wr_ok    = wr_en && cfg_hit && !locked_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             locked_q <= 1'b1;
    else if (key_hit)       locked_q <= (wr_data != UNLOCK_KEY);
    else if (cfg_wr_ok)     locked_q <= 1'b1;
  end

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cfg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                        regs_q[g] <= CFG_RESET;
      else if (cfg_wr_ok && cfg_idx == IDX_W'(g))        regs_q[g] <= cs_cfg_t'(wr_data[7:0]);
    end
  end

  always_comb begin
    rd_data = '0;
    if (cfg_hit)           rd_data = {24'b0, regs_q[cfg_idx]};
    else if (key_hit_addr) rd_data = {31'b0, locked_q};
  end

  assign cfg_q = regs_q;

  a_r7_relock_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_ok |=> locked_q);

  a_r6_guarded_bytes_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && !key_hit) |=> $stable(regs_q));

endmodule

// File: rtl/emc_beat_timer.sv
module emc_beat_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic [CNT_W-1:0] len,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= CNT_W'(1);
    else if (run)     cnt_q <= cnt_q + CNT_W'(1);
  end

  assign last = (cnt_q == len);

  a_r2_count_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q != '0 && cnt_q < len));

  a_r2_restart_at_one: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == CNT_W'(1)));

endmodule

// File: rtl/emc_seq.sv
module emc_seq
  import emc_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int NUM_CS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_cfg,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  input  cs_cfg_t           sel_cfg,
  input  logic [31:0]       reg_rdata,
  input  logic [31:0]       mem_rdata,
  output logic              req_ready,
  output logic              accept,
  output logic              done,
  output logic              err,
  output logic [31:0]       rdata,
  output logic [NUM_CS-1:0] mem_cs_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [31:0]       mem_wdata
);

  localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

  typedef enum logic [1:0] {S_IDLE, S_BEAT, S_CAPT, S_RESP} st_e;

  st_e              state_q, state_d;
  logic [CS_W-1:0]  cs_q;
  logic [ADDR_W-3:0] word_q;
  logic [31:0]      wdata_q, rdata_q;
  logic             write_q, err_q;
  cs_cfg_t          cfg_q;
  logic [1:0]       beat_q;

  logic             reject, go_mem, beat_end, last_beat;
  logic             tmr_last, tmr_restart, tmr_run;
  logic             active, strobe;
  logic             unused_addr_lsb;

  assign unused_addr_lsb = ^req_addr[1:0];

  assign req_ready   = (state_q == S_IDLE);
  assign accept      = req_valid && req_ready;
  assign reject      = req_write && !sel_cfg.wren;
  assign go_mem      = accept && !req_cfg && !reject;
  assign last_beat   = ({1'b0, beat_q} == beat_count(cfg_q.width) - 3'd1);
  assign beat_end    = (state_q == S_BEAT && tmr_last && !cfg_q.sync) || (state_q == S_CAPT);
  assign tmr_restart = go_mem || (beat_end && !last_beat);
  assign tmr_run     = (state_q == S_BEAT) && !tmr_last;

  emc_beat_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (tmr_restart),
    .run     (tmr_run),
    .len     (beat_len(cfg_q.ws)),
    .last    (tmr_last)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: if (accept) state_d = go_mem ? S_BEAT : S_RESP;
      S_BEAT: if (tmr_last)
                state_d = cfg_q.sync ? S_CAPT : (last_beat ? S_RESP : S_BEAT);
      S_CAPT: state_d = last_beat ? S_RESP : S_BEAT;
      S_RESP: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cs_q    <= '0;
      word_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      write_q <= 1'b0;
      err_q   <= 1'b0;
      cfg_q   <= CFG_RESET;
      beat_q  <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        cs_q    <= req_addr[ADDR_W-1 -: CS_W];
        word_q  <= req_addr[ADDR_W-1:2];
        wdata_q <= req_wdata;
        write_q <= req_write;
        cfg_q   <= sel_cfg;
        beat_q  <= '0;
        err_q   <= !req_cfg && reject;
        rdata_q <= req_cfg ? reg_rdata : '0;
      end else if (beat_end) begin
        if (!write_q)   rdata_q <= merge_lane(rdata_q, mem_rdata, beat_q, cfg_q.width);
        if (!last_beat) beat_q  <= beat_q + 2'd1;
      end
    end
  end

  assign active    = (state_q == S_BEAT) || (state_q == S_CAPT);
  assign strobe    = (state_q == S_BEAT);
  assign mem_cs_n  = active ? ~(NUM_CS'(1) << cs_q) : '1;
  assign mem_addr  = {word_q, beat_offset(beat_q, cfg_q.width)};
  assign mem_oe_n  = !(strobe && !write_q);
  assign mem_we_n  = !(strobe && write_q);
  assign mem_wdata = lane_data(wdata_q, beat_q, cfg_q.width);
  assign done      = (state_q == S_RESP);
  assign err       = err_q;
  assign rdata     = rdata_q;

  a_r9_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> req_ready);

  a_r8_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_cs_n));

  a_r8_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  a_r8_strobe_has_select: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n || !mem_we_n) |-> (mem_cs_n != '1));

  a_r4_write_needs_allow: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> cfg_q.wren);

endmodule

// File: rtl/ext_mem_ctrl.sv
module ext_mem_ctrl
  import emc_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int NUM_CS = 4,
  parameter int OFS_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_cfg,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              done,
  output logic              err,
  output logic [31:0]       rdata,
  output logic [NUM_CS-1:0] mem_cs_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata
);

  localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

  cs_cfg_t [NUM_CS-1:0] cfg_all;
  cs_cfg_t              sel_cfg;
  logic                 accept;
  logic                 reg_wr;
  logic [31:0]          reg_rdata;

  assign sel_cfg = cfg_all[req_addr[ADDR_W-1 -: CS_W]];
  assign reg_wr  = accept && req_cfg && req_write;

  emc_cfg_regs #(.NUM_CS(NUM_CS), .OFS_W(OFS_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr),
    .ofs     (req_addr[OFS_W-1:0]),
    .wr_data (req_wdata[15:0]),
    .cfg_q   (cfg_all),
    .rd_data (reg_rdata)
  );

  emc_seq #(.ADDR_W(ADDR_W), .NUM_CS(NUM_CS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_cfg   (req_cfg),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .sel_cfg   (sel_cfg),
    .reg_rdata (reg_rdata),
    .mem_rdata (mem_rdata),
    .req_ready (req_ready),
    .accept    (accept),
    .done      (done),
    .err       (err),
    .rdata     (rdata),
    .mem_cs_n  (mem_cs_n),
    .mem_addr  (mem_addr),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_wdata (mem_wdata)
  );

endmodule

// File: tb/ext_mem_ctrl_tb.sv
`timescale 1ns/1ps
module ext_mem_ctrl_tb;
  localparam int AW  = 26;
  localparam int NCS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          req_valid = 1'b0, req_cfg = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          req_ready, done, err, mem_oe_n, mem_we_n;
  logic [31:0]   rdata, mem_wdata, mem_rdata;
  logic [NCS-1:0] mem_cs_n;
  logic [AW-1:0] mem_addr;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] wmem [256];

  ext_mem_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cfg(req_cfg), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .done(done), .err(err), .rdata(rdata), .mem_cs_n(mem_cs_n), .mem_addr(mem_addr),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] pat(input logic [AW-1:0] a);
    return a[7:0] * 8'd7 + {a[25:24], 6'd0} + 8'd3;
  endfunction

  always_comb begin
    for (int j = 0; j < 4; j++) mem_rdata[8*j +: 8] = pat(mem_addr + AW'(j));
  end

  function automatic int exp_len(input logic [3:0] ws);
    return (ws >= 4'hE) ? 16 : int'(ws) + 2;
  endfunction

  function automatic int exp_beats(input logic [1:0] w);
    return (w == 2'b00) ? 4 : (w == 2'b01) ? 2 : 1;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input bit cfg, input bit wr, input logic [AW-1:0] a, input logic [31:0] wd,
                      input int nbytes, output logic [31:0] rd, output bit e,
                      output int lat, output int strobes, output int bad);
    bad = 0; lat = 0; strobes = 0;
    @(negedge clk);
    if (!req_ready) bad++;
    req_valid = 1'b1; req_cfg = cfg; req_write = wr; req_addr = a; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!done && lat < 400) begin
      if (req_ready) bad++;
      if (!mem_oe_n && !mem_we_n) bad++;
      if (!mem_oe_n || !mem_we_n) begin
        strobes++;
        if (~mem_cs_n != (NCS'(1) << a[AW-1 -: 2])) bad++;
      end
      if (!mem_we_n)
        for (int j = 0; j < nbytes; j++) wmem[mem_addr[7:0] + 8'(j)] = mem_wdata[8*j +: 8];
      lat++;
      @(negedge clk);
    end
    rd = rdata; e = err;
  endtask

  task automatic wrreg(input logic [5:0] ofs, input logic [31:0] v);
    logic [31:0] rd; bit e; int lat, st, bad;
    xfer(1'b1, 1'b1, AW'(ofs), v, 0, rd, e, lat, st, bad);
    chk(lat == 0 && bad == 0 && !e, "R9 register write latency", lat, 0);
  endtask

  task automatic rdreg(input logic [5:0] ofs, output logic [31:0] v);
    bit e; int lat, st, bad;
    xfer(1'b1, 1'b0, AW'(ofs), 32'h0, 0, v, e, lat, st, bad);
    chk(lat == 0 && bad == 0, "R9 register read latency", lat, 0);
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : main
    logic [31:0] v, rd, wd, expw;
    logic [AW-1:0] base;
    bit e;
    int lat, st, bad, idx;
    logic [3:0] wslist [6];
    wslist = '{4'h0, 4'h1, 4'h5, 4'hD, 4'hE, 4'hF};

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 idle outputs after reset
    chk(req_ready && !done, "R1 ready/done after reset", {req_ready, done}, 2'b10);
    chk(mem_cs_n == 4'hF && mem_oe_n && mem_we_n, "R1 bus idle after reset",
        {mem_cs_n, mem_oe_n, mem_we_n}, 6'h3F);
    for (int c = 0; c < 4; c++) begin
      rdreg(6'(c * 4), v);
      chk(v == 32'hF0, "R1 configuration byte reset value", v, 32'hF0);
    end
    rdreg(6'h20, v);
    chk(v == 32'h1, "R1 R7 key register guarded after reset", v, 1);

    // R4 default bytes refuse writes
    xfer(1'b0, 1'b1, {2'd0, 24'h000010}, 32'hDEADBEEF, 1, rd, e, lat, st, bad);
    chk(e && lat == 0 && st == 0 && bad == 0, "R4 default write refused", {e, 8'(lat), 8'(st)}, 32'h10000);
    // R2 R5 default read: four byte beats of 16 cycles
    xfer(1'b0, 1'b0, {2'd0, 24'h000020}, 32'h0, 0, rd, e, lat, st, bad);
    chk(lat == 64 && st == 64 && !e && bad == 0, "R2 default read latency", lat, 64);
    expw = {pat({2'd0,24'h23}), pat({2'd0,24'h22}), pat({2'd0,24'h21}), pat({2'd0,24'h20})};
    chk(rd == expw, "R5 default read data", rd, expw);

    // R6 guarded write ignored
    wrreg(6'h04, 32'h06);
    rdreg(6'h04, v);
    chk(v == 32'hF0, "R6 guarded write ignored", v, 32'hF0);
    // R7 unlock, write, relock
    wrreg(6'h20, 32'hA05F);
    rdreg(6'h20, v);
    chk(v == 32'h0, "R7 key opens guard", v, 0);
    wrreg(6'h04, 32'h06);
    rdreg(6'h04, v);
    chk(v == 32'h06, "R7 open write applies", v, 32'h06);
    rdreg(6'h20, v);
    chk(v == 32'h1, "R7 guard re-armed after write", v, 1);
    wrreg(6'h04, 32'h02);
    rdreg(6'h04, v);
    chk(v == 32'h06, "R6 R7 second write ignored", v, 32'h06);
    // R7 wrong key relocks
    wrreg(6'h20, 32'hA05F);
    wrreg(6'h20, 32'h1234);
    rdreg(6'h20, v);
    chk(v == 32'h1, "R7 wrong key guards", v, 1);
    wrreg(6'h0C, 32'h55);
    rdreg(6'h0C, v);
    chk(v == 32'hF0, "R6 write after wrong key ignored", v, 32'hF0);

    // sweep: select x width x wait code x timing
    idx = 0;
    for (int c = 0; c < 4; c++)
      for (int w = 0; w < 4; w++)
        for (int wi = 0; wi < 6; wi++)
          for (int s = 0; s < 2; s++) begin
            logic [7:0] cv;
            int nb, bl, lexp;
            cv = {wslist[wi], 1'(s), 1'b1, 2'(w)};
            nb = exp_beats(2'(w));
            bl = exp_len(wslist[wi]);
            lexp = nb * (bl + s);
            wrreg(6'h20, 32'hA05F);
            wrreg(6'(c * 4), {24'h0, cv});
            rdreg(6'(c * 4), v);
            chk(v == {24'h0, cv}, "R6 R7 sweep byte write", v, {24'h0, cv});
            base = {2'(c), 16'h0, 8'(idx * 4)};
            wd = 32'h1234_5678 ^ (32'(idx) * 32'h0103_0507);
            for (int k = 0; k < 256; k++) wmem[k] = 8'h00;
            xfer(1'b0, 1'b1, base, wd, 4 / nb, rd, e, lat, st, bad);
            chk(!e, "R4 permitted write err", e, 0);
            chk(lat == lexp, "R2 R3 write latency", lat, lexp);
            chk(st == nb * bl, "R2 write strobe cycles", st, nb * bl);
            chk(bad == 0, "R8 R9 write bus/handshake", bad, 0);
            for (int i = 0; i < 4; i++)
              chk(wmem[base[7:0] + 8'(i)] == wd[8*i +: 8], "R5 written byte",
                  wmem[base[7:0] + 8'(i)], wd[8*i +: 8]);
            xfer(1'b0, 1'b0, base, 32'h0, 0, rd, e, lat, st, bad);
            expw = {pat(base + 3), pat(base + 2), pat(base + 1), pat(base)};
            chk(rd == expw && !e, "R5 read data assembly", rd, expw);
            chk(lat == lexp, "R3 read latency", lat, lexp);
            chk(st == nb * bl, "R2 read strobe cycles", st, nb * bl);
            chk(bad == 0, "R8 R9 read bus/handshake", bad, 0);
            idx++;
          end

    // R4 refused write on a synchronous halfword select, then a read still works
    wrreg(6'h20, 32'hA05F);
    wrreg(6'h08, 32'h39);
    xfer(1'b0, 1'b1, {2'd2, 24'h000040}, 32'hCAFEF00D, 2, rd, e, lat, st, bad);
    chk(e && lat == 0 && st == 0 && bad == 0, "R4 refused write, no bus activity",
        {e, 8'(lat), 8'(st)}, 32'h10000);
    xfer(1'b0, 1'b0, {2'd2, 24'h000040}, 32'h0, 0, rd, e, lat, st, bad);
    chk(lat == 12 && !e, "R3 R4 read on write-blocked select", lat, 12);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule